// File: doc/BRIEF.md
# Two-Dimensional DMA Row Request Generator

This block turns one rectangular transfer request into a series of row requests for a downstream data mover. A request carries a source base address, a destination base address, a separate stride for each side, a row length and a row count. Both lengths are coded as the real value minus one. For every row the block presents a start address on each side, the row length and the row number. The last row is flagged. After the mover takes that last row, a single-cycle completion pulse follows.

Row k starts at the base address plus k times that side's stride. Addresses are 64 bits wide and wrap modulo 2^64. Strides are 32-bit unsigned values. Once a request is accepted, the total byte count of the region is registered and held. A row count of zero gives a plain linear copy: one row, flagged as last.

Parameters set whether row counts are supported at all. Without that support, the row count field has no effect and the whole request is a single row. Parameters also set whether each side is memory or a stream. A stream side has no address, so its row address output stays at zero. Requests use a valid/ready handshake and are taken only while the block is idle. Row requests use their own valid/ready handshake toward the mover.

Top module: `dma2d_rowgen`

## Requirements
- R1: `req_ready` is high exactly when no transfer is in progress, and a request is taken only on a cycle with `req_valid` and `req_ready` both high. In the cycle after acceptance, `row_valid` is high with `row_index` 0. After reset, `req_ready` is 1, and `row_valid`, `done` and `total_bytes` are 0.
- R2: With row counts supported, a request with row count field C yields exactly C+1 row requests, with `row_index` running 0, 1, ..., C.
- R3: On a memory source side, row k presents `row_src_addr` = source base + k × source stride, modulo 2^64.
- R4: On a memory destination side, row k presents `row_dst_addr` = destination base + k × destination stride, modulo 2^64.
- R5: Every row presents `row_len_m1` equal to the request's row length field, which is the byte count per row minus one.
- R6: `row_last` is 1 on the final row only. After the final row is taken, `row_valid` drops in the next cycle.
- R7: `done` is high for exactly one cycle: the cycle after the final row handshake. It is raised once per request.
- R8: From the cycle after acceptance until the next acceptance, `total_bytes` equals (row length field + 1) × (row count field + 1), using 0 for the row count field when row counts are not supported.
- R9: With `HAS_2D` = 0, the row count field is ignored. Every request gives one row with `row_last` = 1, and `total_bytes` = row length field + 1.
- R10: A side configured as a stream (`SRC_MEM` or `DST_MEM` = 0) keeps its row address output at 0.
- R11: While `row_valid` is high and `row_ready` is low, every row output holds its value.
- R12: A request presented while a transfer is in progress is not taken. It changes none of the rows, lengths or totals of the running transfer.
- R13: A synchronous `rst` during a transfer drops `row_valid` in the next cycle, produces no `done`, and returns the block to idle with `total_bytes` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_src_addr | input | ADDR_W | Source base address |
| req_dst_addr | input | ADDR_W | Destination base address |
| req_src_stride | input | STRIDE_W | Source row-to-row stride in bytes |
| req_dst_stride | input | STRIDE_W | Destination row-to-row stride in bytes |
| req_row_len_m1 | input | XLEN_W | Bytes per row minus one |
| req_row_cnt_m1 | input | YLEN_W | Rows minus one |
| row_valid | output | 1 | Row request presented |
| row_ready | input | 1 | Mover takes the row request |
| row_src_addr | output | ADDR_W | Source start address of this row |
| row_dst_addr | output | ADDR_W | Destination start address of this row |
| row_len_m1 | output | XLEN_W | Bytes in this row minus one |
| row_index | output | YLEN_W | Row number within the transfer |
| row_last | output | 1 | This is the final row |
| total_bytes | output | XLEN_W+YLEN_W+1 | Byte count of the accepted transfer |
| done | output | 1 | One-cycle pulse after the final row is taken |

## Verification
The hardest situations to reach from the ports are a new request arriving while rows are still pending, and a reset landing in the middle of a transfer. One table entry keeps `req_valid` high with altered fields for the whole transfer. It also throttles `row_ready` with a periodic pattern, so the stray request meets both stalled and moving cycles. A directed test then resets after two rows have been taken and runs a clean transfer afterwards. A second instance, built without row counts and with a stream source, receives the same request fields and shows the single-row fold and the zero source address.

// File: rtl/dma2d_rowgen.sv
module dma2d_rowgen #(
  parameter int ADDR_W   = 64,
  parameter int STRIDE_W = 32,
  parameter int XLEN_W   = 24,
  parameter int YLEN_W   = 16,
  parameter bit HAS_2D   = 1'b1,
  parameter bit SRC_MEM  = 1'b1,
  parameter bit DST_MEM  = 1'b1,
  localparam int TOT_W   = XLEN_W + YLEN_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_src_addr,
  input  logic [ADDR_W-1:0]   req_dst_addr,
  input  logic [STRIDE_W-1:0] req_src_stride,
  input  logic [STRIDE_W-1:0] req_dst_stride,
  input  logic [XLEN_W-1:0]   req_row_len_m1,
  input  logic [YLEN_W-1:0]   req_row_cnt_m1,
  output logic                row_valid,
  input  logic                row_ready,
  output logic [ADDR_W-1:0]   row_src_addr,
  output logic [ADDR_W-1:0]   row_dst_addr,
  output logic [XLEN_W-1:0]   row_len_m1,
  output logic [YLEN_W-1:0]   row_index,
  output logic                row_last,
  output logic [TOT_W-1:0]    total_bytes,
  output logic                done
);

  logic              busy;
  logic [YLEN_W-1:0] idx;
  logic [YLEN_W-1:0] rows_m1;
  logic [XLEN_W-1:0] len_q;
  logic [TOT_W-1:0]  tot_q;
  logic              done_q;
  logic [YLEN_W-1:0] cnt_eff;

  wire accept  = req_valid && !busy;
  wire fire    = busy && row_ready;
  wire at_last = (idx == rows_m1);

  generate
    if (HAS_2D) begin : g_2d
      assign cnt_eff = req_row_cnt_m1;
    end else begin : g_1d
      assign cnt_eff = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      rows_m1 <= '0;
      len_q   <= '0;
      tot_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire && at_last;
      if (accept) begin
        busy    <= 1'b1;
        idx     <= '0;
        rows_m1 <= cnt_eff;
        len_q   <= req_row_len_m1;
        tot_q   <= (TOT_W'(req_row_len_m1) + 1'b1) * (TOT_W'(cnt_eff) + 1'b1);
      end else if (fire) begin
        if (at_last) busy <= 1'b0;
        else         idx  <= idx + 1'b1;
      end
    end
  end

  generate
    if (SRC_MEM) begin : g_src_mem
      logic [ADDR_W-1:0]   src_q;
      logic [STRIDE_W-1:0] sstr_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          src_q  <= '0;
          sstr_q <= '0;
        end else if (accept) begin
          src_q  <= req_src_addr;
          sstr_q <= req_src_stride;
        end else if (fire && !at_last) begin
          src_q  <= src_q + ADDR_W'(sstr_q);
        end
      end
      assign row_src_addr = src_q;
    end else begin : g_src_stream
      assign row_src_addr = '0;
    end

    if (DST_MEM) begin : g_dst_mem
      logic [ADDR_W-1:0]   dst_q;
      logic [STRIDE_W-1:0] dstr_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          dst_q  <= '0;
          dstr_q <= '0;
        end else if (accept) begin
          dst_q  <= req_dst_addr;
          dstr_q <= req_dst_stride;
        end else if (fire && !at_last) begin
          dst_q  <= dst_q + ADDR_W'(dstr_q);
        end
      end
      assign row_dst_addr = dst_q;
    end else begin : g_dst_stream
      assign row_dst_addr = '0;
    end
  endgenerate

  assign req_ready   = !busy;
  assign row_valid   = busy;
  assign row_index   = idx;
  assign row_len_m1  = len_q;
  assign row_last    = busy && at_last;
  assign total_bytes = tot_q;
  assign done        = done_q;

endmodule

module dma2d_rowgen_chk #(
  parameter int ADDR_W  = 64,
  parameter int XLEN_W  = 24,
  parameter int YLEN_W  = 16,
  parameter int TOT_W   = 41,
  parameter bit HAS_2D  = 1'b1,
  parameter bit SRC_MEM = 1'b1,
  parameter bit DST_MEM = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              row_valid,
  input logic              row_ready,
  input logic [ADDR_W-1:0] row_src_addr,
  input logic [ADDR_W-1:0] row_dst_addr,
  input logic [XLEN_W-1:0] row_len_m1,
  input logic [YLEN_W-1:0] row_index,
  input logic              row_last,
  input logic [TOT_W-1:0]  total_bytes,
  input logic              done
);

  a_r1_accept_starts: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> row_valid && row_index == '0);

  a_r2_index_step: assert property (@(posedge clk) disable iff (rst)
    row_valid && row_ready && !row_last |=> row_valid && row_index == $past(row_index) + 1'b1);

  a_r5_len_stable: assert property (@(posedge clk) disable iff (rst)
    row_valid && row_ready && !row_last |=> $stable(row_len_m1));

  a_r6_last_drops: assert property (@(posedge clk) disable iff (rst)
    row_valid && row_ready && row_last |=> !row_valid);

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    row_valid && row_ready && row_last |=> done);

  a_r7_done_once: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_total_held: assert property (@(posedge clk) disable iff (rst)
    row_valid && $past(row_valid) |-> $stable(total_bytes));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    row_valid && !row_ready |=> row_valid && $stable(row_src_addr) && $stable(row_dst_addr)
      && $stable(row_index) && $stable(row_last) && $stable(row_len_m1));

  generate
    if (!HAS_2D) begin : g_chk_1d
      a_r9_single_row: assert property (@(posedge clk) disable iff (rst)
        row_valid |-> row_last);
    end
    if (!SRC_MEM) begin : g_chk_src
      a_r10_src_zero: assert property (@(posedge clk) disable iff (rst)
        row_src_addr == '0);
    end
    if (!DST_MEM) begin : g_chk_dst
      a_r10_dst_zero: assert property (@(posedge clk) disable iff (rst)
        row_dst_addr == '0);
    end
  endgenerate

endmodule

bind dma2d_rowgen dma2d_rowgen_chk #(
  .ADDR_W(ADDR_W), .XLEN_W(XLEN_W), .YLEN_W(YLEN_W), .TOT_W(XLEN_W + YLEN_W + 1),
  .HAS_2D(HAS_2D), .SRC_MEM(SRC_MEM), .DST_MEM(DST_MEM)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .row_valid(row_valid), .row_ready(row_ready), .row_src_addr(row_src_addr),
  .row_dst_addr(row_dst_addr), .row_len_m1(row_len_m1), .row_index(row_index),
  .row_last(row_last), .total_bytes(total_bytes), .done(done)
);

// File: tb/test_dma2d_rowgen.sv
module test_dma2d_rowgen;

  typedef struct packed {
    logic [63:0] src;
    logic [63:0] dst;
    logic [31:0] ss;
    logic [31:0] ds;
    logic [23:0] len;
    logic [15:0] cnt;
    logic        bp;
    logic        ign;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{64'h1000, 64'h8000_0000, 32'h100, 32'h200, 24'd63, 16'd0, 1'b0, 1'b0},
    '{64'h2000, 64'h1_0000, 32'h40, 32'h80, 24'd31, 16'd3, 1'b0, 1'b0},
    '{64'h1_0000_0000, 64'h3000, 32'hFFFF_FFFF, 32'h1, 24'd0, 16'd5, 1'b1, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FFF0, 32'h80, 32'h10, 24'hFF_FFFF, 16'd2, 1'b0, 1'b0},
    '{64'h5000, 64'h6000, 32'h10, 32'h20, 24'd7, 16'd19, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, b_req_valid = 1'b0;
  logic [63:0] req_src = '0, req_dst = '0;
  logic [31:0] req_ss = '0, req_ds = '0;
  logic [23:0] req_len = '0;
  logic [15:0] req_cnt = '0;
  logic        row_ready = 1'b0;
  logic        b_row_ready = 1'b1;

  logic        req_ready, row_valid, row_last, done;
  logic [63:0] row_src, row_dst;
  logic [23:0] row_len;
  logic [15:0] row_index;
  logic [40:0] total;
  logic        b_req_ready, b_row_valid, b_row_last, b_done;
  logic [63:0] b_row_src, b_row_dst;
  logic [23:0] b_row_len;
  logic [15:0] b_row_index;
  logic [40:0] b_total;

  int nchecks = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  dma2d_rowgen i_dma2d_rowgen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_src_addr(req_src), .req_dst_addr(req_dst), .req_src_stride(req_ss),
    .req_dst_stride(req_ds), .req_row_len_m1(req_len), .req_row_cnt_m1(req_cnt),
    .row_valid(row_valid), .row_ready(row_ready), .row_src_addr(row_src),
    .row_dst_addr(row_dst), .row_len_m1(row_len), .row_index(row_index),
    .row_last(row_last), .total_bytes(total), .done(done)
  );

  dma2d_rowgen #(.HAS_2D(1'b0), .SRC_MEM(1'b0)) i_dma2d_rowgen_flat (
    .clk(clk), .rst(rst), .req_valid(b_req_valid), .req_ready(b_req_ready),
    .req_src_addr(req_src), .req_dst_addr(req_dst), .req_src_stride(req_ss),
    .req_dst_stride(req_ds), .req_row_len_m1(req_len), .req_row_cnt_m1(req_cnt),
    .row_valid(b_row_valid), .row_ready(b_row_ready), .row_src_addr(b_row_src),
    .row_dst_addr(b_row_dst), .row_len_m1(b_row_len), .row_index(b_row_index),
    .row_last(b_row_last), .total_bytes(b_total), .done(b_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int rows = int'(v.cnt) + 1;
    int k = 0;
    int cyc = 0;
    int guard = 0;
    logic [63:0] es, ed;
    logic [40:0] etot = (41'(v.len) + 1) * (41'(v.cnt) + 1);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 idle ready", 64'(req_ready), 64'd1);
    req_src = v.src; req_dst = v.dst; req_ss = v.ss; req_ds = v.ds;
    req_len = v.len; req_cnt = v.cnt;
    req_valid = 1'b1; b_req_valid = 1'b1; row_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    b_req_valid = 1'b0;
    req_valid = v.ign;
    chk(b_row_valid && b_row_last, "R9 flat single last row", {62'd0, b_row_valid, b_row_last}, 64'd3);
    chk(b_total == 41'(v.len) + 1, "R9 flat total", 64'(b_total), 64'(v.len) + 1);
    chk(b_row_src == '0, "R10 stream source zero", b_row_src, 64'd0);
    chk(b_row_dst == v.dst, "R4 flat destination", b_row_dst, v.dst);
    chk(req_ready == 1'b0, "R1 busy not ready", 64'(req_ready), 64'd0);
    if (v.ign) begin
      req_src = ~v.src; req_dst = ~v.dst; req_ss = v.ss + 5; req_ds = v.ds + 7;
      req_len = v.len ^ 24'h1; req_cnt = v.cnt + 3;
    end
    while (k < rows && guard < 4000) begin
      es = v.src + 64'(k) * 64'(v.ss);
      ed = v.dst + 64'(k) * 64'(v.ds);
      chk(row_valid == 1'b1, "R2 row valid", 64'(row_valid), 64'd1);
      chk(row_index == 16'(k), v.ign ? "R12 R2 row index" : "R2 row index", 64'(row_index), 64'(k));
      chk(row_src == es, v.ign ? "R12 R3 source" : "R3 source address", row_src, es);
      chk(row_dst == ed, v.ign ? "R12 R4 destination" : "R4 destination address", row_dst, ed);
      chk(row_len == v.len, "R5 row length", 64'(row_len), 64'(v.len));
      chk(row_last == (k == rows - 1), "R6 last flag", 64'(row_last), 64'(k == rows - 1));
      chk(total == etot, "R8 total bytes", 64'(total), 64'(etot));
      row_ready = v.bp ? (cyc % 3 != 1) : 1'b1;
      cyc++;
      if (k == rows - 1 && row_ready) req_valid = 1'b0;
      @(posedge clk);
      if (row_ready) k++;
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b0;
    chk(done == 1'b1, "R7 done after last", 64'(done), 64'd1);
    chk(row_valid == 1'b0, "R6 rows stop", 64'(row_valid), 64'd0);
    chk(req_ready == 1'b1, "R1 idle again", 64'(req_ready), 64'd1);
    row_ready = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", 64'(done), 64'd0);
    chk(total == etot, "R8 total held after done", 64'(total), 64'(etot));
  endtask

  initial begin
    #(4 * 150000);
    nchecks++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(row_valid == 1'b0, "R1 reset row_valid", 64'(row_valid), 64'd0);
    chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
    chk(total == '0, "R1 reset total", 64'(total), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R13: reset in the middle of a transfer
    @(negedge clk);
    req_src = 64'h9000; req_dst = 64'hA000; req_ss = 32'h8; req_ds = 32'h8;
    req_len = 24'd3; req_cnt = 16'd9; req_valid = 1'b1; row_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(row_index == 16'd2, "R13 progress before reset", 64'(row_index), 64'd2);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    row_ready = 1'b0;
    chk(row_valid == 1'b0, "R13 rows dropped", 64'(row_valid), 64'd0);
    chk(done == 1'b0, "R13 no done", 64'(done), 64'd0);
    chk(req_ready == 1'b1, "R13 idle after reset", 64'(req_ready), 64'd1);
    chk(total == '0, "R13 total cleared", 64'(total), 64'd0);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R13 no late done", 64'(done), 64'd0);
    run_vec(VEC[1]);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

endmodule